// File: doc/BRIEF.md
# HDLC Bit-Serial Transmit Framer

The framer turns a stream of bytes into a bit-serial HDLC line signal. Bytes arrive over a valid/ready handshake, and a last-byte marker ends each frame. The line moves forward by one bit on every clock cycle in which `bit_en` is high. The framer wraps each frame in flag octets (0x7E). After the payload it appends a frame check sequence: either a 16-bit CRC or a 32-bit CRC. Inside the payload and the check sequence it inserts a zero after every run of five ones, so that the flag pattern cannot appear in the middle of a frame.

Three static configuration inputs are sampled while the block is running and are meant to be changed only under reset:
- `cfg_crc32` picks the check sequence width.
- `cfg_share_flag` lets a single flag close one frame and open the next.
- `cfg_idle_flags` picks the line fill between frames: continuous ones, or repeated whole flags.

The source must keep bytes coming within a frame. If `in_valid` is low at a byte boundary inside a frame, the framer pauses and holds the line until a byte is offered.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst` is high, `tx_bit` is 1 and `in_ready` is 0.
- R2: Between frames the line carries continuous ones when `cfg_idle_flags`=0. When `cfg_idle_flags`=1 it carries back-to-back whole flags, starting with the first line bit after reset. A waiting frame never cuts an idle flag short.
- R3: Each frame is closed by a flag. After a period of idle ones, exactly one opening flag comes before the payload. A flag is 0x7E, sent as 0,1,1,1,1,1,1,0, and no zero is ever inserted into it.
- R4: Payload bytes go out least significant bit first, one line bit per clock cycle with `bit_en` high. `tx_bit` does not change in a cycle with `bit_en` low.
- R5: After five consecutive ones within the payload and check sequence, a single 0 is inserted. This also applies when the run of ones crosses a byte boundary, the payload/check-sequence boundary, or the boundary into the closing flag.
- R6: With `cfg_crc32`=0, the check sequence is the 16-bit CRC:
  - polynomial x^16+x^12+x^5+1, processed LSB-first;
  - register preset to all ones;
  - the complemented remainder is sent LSB first.
  For the bytes "123456789" the sent value is 0x906E.
- R7: With `cfg_crc32`=1, the check sequence is the 32-bit CRC with the Ethernet polynomial, preset to all ones, complemented and sent LSB first. For the bytes "123456789" the sent value is 0xCBF43926.
- R8: When the first byte of the next frame is already offered as a frame ends, the two frames are separated by exactly one flag if `cfg_share_flag`=1, and by exactly two flags otherwise.
- R9: `in_ready` is high only in a cycle with `bit_en` high in which the first bit of a payload byte goes onto the line. It is low during flags, the check sequence, inserted zeros and idle fill. A byte is taken when `in_valid` and `in_ready` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_crc32 | input | 1 | 1 selects the 32-bit check sequence, 0 the 16-bit one |
| cfg_share_flag | input | 1 | 1 lets one flag close a frame and open the next |
| cfg_idle_flags | input | 1 | 1 fills idle time with flags, 0 with ones |
| bit_en | input | 1 | Advance the line by one bit this cycle |
| in_valid | input | 1 | A payload byte is offered |
| in_data | input | DATA_W | Payload byte |
| in_last | input | 1 | The offered byte is the last one of its frame |
| in_ready | output | 1 | The offered byte is taken at this edge |
| tx_bit | output | 1 | Serial line output |

## Verification
`tx_bit` is a register. It takes its new value at the same edge at which `bit_en` is sampled high, so each line bit is due one edge after its enabling cycle. The bench logs the line at the falling edge that follows each enabled rising edge, and then parses the log bit by bit against a stream built independently from the frame contents. `in_ready` is combinational from `bit_en` and state, so it is due in the same cycle. The bench changes `bit_en` on the falling edge and reads `in_ready` a moment later, well before the rising edge that completes the handshake. The same sweep runs over every configuration combination, and also with `bit_en` pulsed once every three cycles.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int          FLAG_W      = 8;
    localparam logic [7:0]  FLAG_PAT    = 8'h7E;
    localparam int          STUFF_RUN   = 5;
    localparam int          FCS16_W     = 16;
    localparam int          FCS32_W     = 32;
    localparam logic [15:0] POLY16_REFL = 16'h8408;
    localparam logic [31:0] POLY32_REFL = 32'hEDB88320;
    localparam int          FI_W        = $clog2(FLAG_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE
    } tx_state_t;

    // One bit of a reflected CRC. Bit 0 of the register meets the line first.
    function automatic logic [FCS32_W-1:0] crc_step(
        input logic [FCS32_W-1:0] cur,
        input logic               din,
        input logic               wide
    );
        logic fb;
        fb = cur[0] ^ din;
        if (wide)
            crc_step = (cur >> 1) ^ (fb ? POLY32_REFL : '0);
        else
            crc_step = {16'h0, cur[15:1] ^ (fb ? POLY16_REFL : 16'h0)};
    endfunction

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
    import hdlc_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               preset,
    input  logic               en,
    input  logic               bit_in,
    input  logic               wide,
    output logic [FCS32_W-1:0] crc_nxt
);

    logic [FCS32_W-1:0] crc_q;

    assign crc_nxt = crc_step(crc_q, bit_in, wide);

    always_ff @(posedge clk) begin
        if (rst || preset)
            crc_q <= '1;
        else if (en)
            crc_q <= crc_nxt;
    end

endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic pay,
    input  logic bit_in,
    output logic stuff_due
);

    localparam int RW = $clog2(RUN + 1);

    logic [RW-1:0] ones;

    assign stuff_due = (ones == RW'(RUN));

    always_ff @(posedge clk) begin
        if (rst)
            ones <= '0;
        else if (adv) begin
            if (stuff_due || !pay || !bit_in)
                ones <= '0;
            else
                ones <= ones + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_crc32,
    input  logic               cfg_share_flag,
    input  logic               cfg_idle_flags,
    input  logic               bit_en,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_last,
    input  logic               stuff_due,
    input  logic [FCS32_W-1:0] crc_nxt,
    output logic               emit,
    output logic               pay,
    output logic               obit,
    output logic               crc_en,
    output logic               crc_preset,
    output logic               in_ready,
    output logic               tx_bit,
    output tx_state_t          st
);

    localparam int SH_W  = (DATA_W > FCS32_W) ? DATA_W : FCS32_W;
    localparam int CNT_W = $clog2(SH_W);

    logic [CNT_W-1:0] cnt, nxt_cnt, fcs_last;
    logic [SH_W-1:0]  sh, nxt_sh;
    logic             last, nxt_last;
    tx_state_t        nxt_st;
    logic             flag_end;
    logic             byte_end;

    assign fcs_last   = cfg_crc32 ? CNT_W'(FCS32_W - 1) : CNT_W'(FCS16_W - 1);
    assign flag_end   = (cnt == CNT_W'(FLAG_W - 1));
    assign byte_end   = (cnt == CNT_W'(DATA_W - 1));
    assign crc_preset = (st != ST_DATA);
    assign in_ready   = bit_en && !stuff_due && (st == ST_DATA) && (cnt == '0);

    always_comb begin
        nxt_st   = st;
        nxt_cnt  = cnt;
        nxt_sh   = sh;
        nxt_last = last;
        emit     = 1'b0;
        pay      = 1'b0;
        obit     = tx_bit;
        crc_en   = 1'b0;
        if (bit_en) begin
            if (stuff_due) begin
                emit = 1'b1;
                obit = 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        emit = 1'b1;
                        if (in_valid && (!cfg_idle_flags || cnt == '0)) begin
                            obit    = FLAG_PAT[0];
                            nxt_st  = ST_OPEN;
                            nxt_cnt = CNT_W'(1);
                        end else if (cfg_idle_flags) begin
                            obit    = FLAG_PAT[cnt[FI_W-1:0]];
                            nxt_cnt = flag_end ? '0 : cnt + 1'b1;
                        end else begin
                            obit    = 1'b1;
                            nxt_cnt = '0;
                        end
                    end
                    ST_OPEN: begin
                        emit = 1'b1;
                        obit = FLAG_PAT[cnt[FI_W-1:0]];
                        if (flag_end) begin
                            nxt_st  = ST_DATA;
                            nxt_cnt = '0;
                        end else begin
                            nxt_cnt = cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == '0) begin
                            if (in_valid) begin
                                emit     = 1'b1;
                                pay      = 1'b1;
                                crc_en   = 1'b1;
                                obit     = in_data[0];
                                nxt_sh   = SH_W'(in_data);
                                nxt_last = in_last;
                                nxt_cnt  = CNT_W'(1);
                            end
                        end else begin
                            emit   = 1'b1;
                            pay    = 1'b1;
                            crc_en = 1'b1;
                            obit   = sh[cnt];
                            if (byte_end) begin
                                nxt_cnt = '0;
                                if (last) begin
                                    nxt_st = ST_FCS;
                                    nxt_sh = SH_W'(~crc_nxt);
                                end
                            end else begin
                                nxt_cnt = cnt + 1'b1;
                            end
                        end
                    end
                    ST_FCS: begin
                        emit = 1'b1;
                        pay  = 1'b1;
                        obit = sh[cnt];
                        if (cnt == fcs_last) begin
                            nxt_st  = ST_CLOSE;
                            nxt_cnt = '0;
                        end else begin
                            nxt_cnt = cnt + 1'b1;
                        end
                    end
                    ST_CLOSE: begin
                        emit = 1'b1;
                        obit = FLAG_PAT[cnt[FI_W-1:0]];
                        if (flag_end) begin
                            nxt_cnt = '0;
                            if (!in_valid)
                                nxt_st = ST_IDLE;
                            else if (cfg_share_flag)
                                nxt_st = ST_DATA;
                            else
                                nxt_st = ST_OPEN;
                        end else begin
                            nxt_cnt = cnt + 1'b1;
                        end
                    end
                    default: nxt_st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            last   <= 1'b0;
            tx_bit <= 1'b1;
        end else begin
            st   <= nxt_st;
            cnt  <= nxt_cnt;
            sh   <= nxt_sh;
            last <= nxt_last;
            if (emit)
                tx_bit <= obit;
        end
    end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_crc32,
    input  logic              cfg_share_flag,
    input  logic              cfg_idle_flags,
    input  logic              bit_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              tx_bit
);

    logic               stuff_due;
    logic               emit, pay, obit;
    logic               crc_en, crc_preset;
    logic [FCS32_W-1:0] crc_nxt;
    tx_state_t          st;

    hdlc_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .cfg_crc32      (cfg_crc32),
        .cfg_share_flag (cfg_share_flag),
        .cfg_idle_flags (cfg_idle_flags),
        .bit_en         (bit_en),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_last        (in_last),
        .stuff_due      (stuff_due),
        .crc_nxt        (crc_nxt),
        .emit           (emit),
        .pay            (pay),
        .obit           (obit),
        .crc_en         (crc_en),
        .crc_preset     (crc_preset),
        .in_ready       (in_ready),
        .tx_bit         (tx_bit),
        .st             (st)
    );

    hdlc_tx_stuff #(.RUN(STUFF_RUN)) u_stuff (
        .clk       (clk),
        .rst       (rst),
        .adv       (emit),
        .pay       (pay),
        .bit_in    (obit),
        .stuff_due (stuff_due)
    );

    hdlc_tx_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .preset  (crc_preset),
        .en      (crc_en),
        .bit_in  (obit),
        .wide    (cfg_crc32),
        .crc_nxt (crc_nxt)
    );

endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker
    import hdlc_tx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      cfg_idle_flags,
    input logic      bit_en,
    input logic      in_valid,
    input logic      in_ready,
    input logic      tx_bit,
    input logic      stuff_due,
    input tx_state_t st
);

    // R1: line parked high, no byte taken while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            a_r1_reset_quiet: assert (!in_ready)
                else $error("R1 in_ready high in reset");
        end
    end

    // R2: idle-ones mode puts a 1 on the line when no frame waits
    a_r2_idle_ones: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && bit_en && !stuff_due && !cfg_idle_flags && !in_valid) |=> tx_bit);

    // R4: the line holds when not enabled
    a_r4_hold_line: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit));

    // R5: an inserted bit is a zero
    a_r5_stuff_zero: assert property (@(posedge clk) disable iff (rst)
        (stuff_due && bit_en) |=> !tx_bit);

    // R9: a byte is only taken on an enabled step
    a_r9_ready_needs_en: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> bit_en);

    // R9: a byte is only taken in the payload phase
    a_r9_ready_in_data: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (st == ST_DATA));

    // R9: never while a zero is being inserted
    a_r9_no_ready_on_stuff: assert property (@(posedge clk) disable iff (rst)
        stuff_due |-> !in_ready);

endmodule

bind hdlc_tx_framer hdlc_tx_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_idle_flags (cfg_idle_flags),
    .bit_en         (bit_en),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .tx_bit         (tx_bit),
    .stuff_due      (stuff_due),
    .st             (st)
);

// File: tb/test_hdlc_tx_framer.sv
`timescale 1ns/100ps
module test_hdlc_tx_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       cfg_crc32 = 1'b0;
    logic       cfg_share_flag = 1'b0;
    logic       cfg_idle_flags = 1'b0;
    logic       in_ready;
    logic       tx_bit;

    hdlc_tx_framer #(.DATA_W(8)) i_hdlc_tx_framer (
        .clk            (clk),
        .rst            (rst),
        .cfg_crc32      (cfg_crc32),
        .cfg_share_flag (cfg_share_flag),
        .cfg_idle_flags (cfg_idle_flags),
        .bit_en         (bit_en),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_last        (in_last),
        .in_ready       (in_ready),
        .tx_bit         (tx_bit)
    );

    always #2.5 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 0;
    int  div = 1;
    int  divc = 0;
    logic stp = 1'b0;
    bit  lbits [0:4095];
    int  nrec = 0;
    bit  rec_on = 0;
    int  bad_ready = 0;
    bit  eb [0:1023];
    int  ne;

    // bit enable pattern, changed away from the rising edge
    always @(negedge clk) begin
        divc   = (divc + 1 >= div) ? 0 : divc + 1;
        bit_en = (divc == 0);
    end

    // a line bit is due one edge after its enabled cycle
    always @(posedge clk) stp <= bit_en && !rst;

    always @(negedge clk) begin
        if (rec_on && stp && nrec < 4096) begin
            lbits[nrec] = tx_bit;
            nrec++;
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst && in_ready && !bit_en) bad_ready++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int frame_len(input int k);
        case (k)
            0: return 9;
            1: return 4;
            2: return 1;
            3: return 6;
            default: return 3;
        endcase
    endfunction

    function automatic logic [7:0] frame_byte(input int k, input int i);
        case (k)
            0: return 8'h31 + 8'(i);
            1: return 8'hFF;
            2: return 8'h7E;
            3: return 8'(i * 37 + 5);
            default: return 8'hF8 ^ 8'(i);
        endcase
    endfunction

    function automatic bit gap_before(input int k);
        return (k == 0) || (k == 2);
    endfunction

    // MSB-first polynomial division on bit-reversed input, reflected at the end
    function automatic logic [31:0] ref_fcs(input int k, input bit wide);
        logic [31:0] c;
        logic [31:0] r;
        logic        fb;
        int          w;
        w = wide ? 32 : 16;
        c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        for (int i = 0; i < frame_len(k); i++) begin
            for (int j = 0; j < 8; j++) begin
                if (wide) begin
                    fb = c[31] ^ frame_byte(k, i)[j];
                    c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
                end else begin
                    fb = c[15] ^ frame_byte(k, i)[j];
                    c  = {16'h0, c[14:0], 1'b0} ^ (fb ? 32'h0000_1021 : 32'h0);
                end
            end
        end
        r = '0;
        for (int i = 0; i < w; i++) r[i] = c[w - 1 - i];
        return wide ? ~r : {16'h0, ~r[15:0]};
    endfunction

    function automatic bit is_flag(input int p);
        if (p + 8 > nrec) return 0;
        return lbits[p] == 0 && lbits[p+1] && lbits[p+2] && lbits[p+3] &&
               lbits[p+4] && lbits[p+5] && lbits[p+6] && lbits[p+7] == 0;
    endfunction

    function automatic bit is_ones8(input int p);
        if (p + 8 > nrec) return 0;
        for (int i = 0; i < 8; i++) if (!lbits[p+i]) return 0;
        return 1;
    endfunction

    task automatic push_stuffed(input bit b, inout int run);
        eb[ne] = b;
        ne++;
        run = b ? run + 1 : 0;
        if (run == 5) begin
            eb[ne] = 0;
            ne++;
            run = 0;
        end
    endtask

    task automatic build_seg(input int k, input bit wide);
        int          run;
        logic [31:0] f;
        run = 0;
        ne  = 0;
        for (int i = 0; i < frame_len(k); i++)
            for (int j = 0; j < 8; j++) push_stuffed(frame_byte(k, i)[j], run);
        f = ref_fcs(k, wide);
        for (int j = 0; j < (wide ? 32 : 16); j++) push_stuffed(f[j], run);
    endtask

    task automatic run_cfg(input bit c32, input bit sh, input bit idf, input int dv);
        int pos;
        int nf;
        int no;
        int mism;
        bit acc;
        in_valid       = 0;
        in_last        = 0;
        rst            = 1;
        cfg_crc32      = c32;
        cfg_share_flag = sh;
        cfg_idle_flags = idf;
        div            = dv;
        rec_on         = 0;
        nrec           = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        chk(tx_bit == 1'b1 && in_ready == 1'b0, "R1", "line/ready in reset",
            {tx_bit, in_ready}, 2'b10);
        bad_ready = 0;
        rec_on    = 1;
        rst       = 0;
        repeat (40 * dv) @(posedge clk);
        #1;
        for (int k = 0; k < 5; k++) begin
            if (gap_before(k) && k > 0) begin
                in_valid = 0;
                repeat (150 * dv) @(posedge clk);
                #1;
            end
            for (int i = 0; i < frame_len(k); i++) begin
                in_valid = 1;
                in_data  = frame_byte(k, i);
                in_last  = (i == frame_len(k) - 1);
                acc      = 0;
                while (!acc) begin
                    @(negedge clk);
                    #1;
                    if (in_ready) acc = 1;
                    @(posedge clk);
                    #1;
                end
            end
        end
        in_valid = 0;
        in_last  = 0;
        repeat (150 * dv) @(posedge clk);
        #1;
        rec_on = 0;

        // R2: start of the idle line
        chk(idf ? is_flag(0) : is_ones8(0), "R2", "idle fill after reset",
            {lbits[0], lbits[1], lbits[2], lbits[3], lbits[4], lbits[5], lbits[6], lbits[7]},
            idf ? 8'h7E : 8'hFF);

        pos = 0;
        for (int k = 0; k < 5; k++) begin
            nf = 0;
            if (k > 0) begin
                chk(is_flag(pos), "R3", "closing flag", k, k);
                pos += 8;
                nf = 1;
            end
            if (gap_before(k) && !idf) begin
                no = 0;
                while (pos < nrec && lbits[pos]) begin
                    pos++;
                    no++;
                end
                nf = 0;
                while (is_flag(pos)) begin
                    pos += 8;
                    nf++;
                end
                chk(no > 0 && nf == 1, "R3", "idle ones then one opening flag",
                    nf, 1);
            end else if (gap_before(k)) begin
                while (is_flag(pos)) begin
                    pos += 8;
                    nf++;
                end
                chk(nf >= 2, "R2", "whole idle flags before frame", nf, 2);
            end else begin
                while (is_flag(pos)) begin
                    pos += 8;
                    nf++;
                end
                chk(nf == (sh ? 1 : 2), "R8", "flags between back-to-back frames",
                    nf, sh ? 1 : 2);
            end
            build_seg(k, c32);
            mism = 0;
            for (int j = 0; j < ne; j++)
                if (pos + j >= nrec || lbits[pos + j] != eb[j]) mism++;
            if (c32)
                chk(mism == 0, "R4 R5 R7", "payload+fcs bit mismatches", mism, 0);
            else
                chk(mism == 0, "R4 R5 R6", "payload+fcs bit mismatches", mism, 0);
            pos += ne;
        end
        chk(is_flag(pos), "R3", "final closing flag", pos, pos);
        pos += 8;
        chk(idf ? is_flag(pos) : is_ones8(pos), "R2", "idle after last frame", pos, pos);
        chk(bad_ready == 0, "R9", "ready without bit enable", bad_ready, 0);
    endtask

    initial begin
        // reference check values for the bench's own CRC
        chk(ref_fcs(0, 0) == 32'h906E, "R6", "16-bit check value", ref_fcs(0, 0), 32'h906E);
        chk(ref_fcs(0, 1) == 32'hCBF43926, "R7", "32-bit check value", ref_fcs(0, 1), 32'hCBF43926);
        for (int c = 0; c < 8; c++)
            run_cfg(c[0], c[1], c[2], 1);
        run_cfg(1'b0, 1'b1, 1'b0, 3);
        run_cfg(1'b1, 1'b0, 1'b1, 3);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule